// File: doc/BRIEF.md
# Bus Status to Command Decoder

This block turns a 3-bit bus status code from a processor into the command and control strobes that memory, I/O devices and an interrupt controller need. The processor does not drive read and write strobes directly. It puts a status code on three lines. The decoder sees the code leave the idle (passive) value, steps through a T1–T2–T3–(wait)–T4 bus cycle, and produces an address latch pulse, a data direction level, a data enable window and one or two active-low commands chosen by the code.

Wait states are added between T3 and T4 for as long as the ready input stays low at the end of T3 and of each wait state. Write cycles drive two commands. The advanced write command starts in T2, one state before the normal write command, which starts in T3. A new cycle can begin directly after T4 if the status went back to passive and then left it again.

Top module: `bus_cmd_decoder`

## Requirements
- R1: A cycle starts, with T1 in the next clock, when the state is idle or T4, the status seen at this edge is not 111, and the status seen at the previous edge was 111. A status change while T1, T2, T3 or a wait state is active has no effect on the outputs.
- R2: The status code is captured at the start of the cycle. 000 is interrupt acknowledge, 001 is I/O read, 010 is I/O write, 011 is halt, 100 is code fetch, 101 is memory read, 110 is memory write and 111 is passive. Code fetch and memory read both drive `mem_rd_n`.
- R3: `ale` is high for exactly the T1 clock of every cycle, halt included.
- R4: `dir_tx` is high from T1 through T4 of I/O write and memory write cycles. It is low for all other codes and whenever no cycle is active.
- R5: `den` is high from T2 through T4, wait states included, for every code except halt.
- R6: `mem_rd_n` and `io_rd_n` are low from T2 through T4 of their cycles.
- R7: `ack_n` is low from T2 through T4 of an interrupt acknowledge cycle.
- R8: `mem_awr_n` and `io_awr_n` are low from T2 through T4 of memory write and I/O write cycles.
- R9: `mem_wr_n` and `io_wr_n` are low from T3 through T4 of memory write and I/O write cycles, so each normal write starts one clock after its advanced write.
- R10: A halt cycle asserts no command and no `den`.
- R11: When `rdy` is low at the end of T3, wait states follow until an edge finds `rdy` high, and then T4 follows. All strobes hold their T3 levels through the wait states.
- R12: While `rst_n` is low, every command is high and `ale`, `dir_tx` and `den` are low.
- R13: All commands and `den` are released in the clock after T4, unless a new cycle starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat | input | 3 | Bus cycle status code; 111 means passive |
| rdy | input | 1 | High when the addressed device can finish the transfer |
| ale | output | 1 | Address latch pulse in T1 |
| dir_tx | output | 1 | Data direction; high means transmit (write) |
| den | output | 1 | Data transceiver enable |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| mem_awr_n | output | 1 | Advanced memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| io_awr_n | output | 1 | Advanced I/O write command, active low |
| ack_n | output | 1 | Interrupt acknowledge strobe, active low |

## Verification
The bench drives every status code with zero, one and several wait states, and compares all ten outputs every clock against a behavioural model. A design that starts the normal write together with the advanced one, or that lets the strobes drop during a wait state, differs from the model at that clock. Back-to-back cycles that restart straight from T4 catch a decoder that needs an idle clock between cycles, or that keeps the old code's command into the new T1. Status changes in the middle of a cycle, and a status that never returns to passive, catch a decoder that triggers on any non-passive code rather than on the edge leaving passive. Halt cycles catch a design that raises `den` or a command for a code that has no command.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stat,
  input  logic       rdy,
  output logic       ale,
  output logic       dir_tx,
  output logic       den,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_awr_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_awr_n,
  output logic       ack_n
);

  localparam logic [2:0] C_ACK  = 3'b000;
  localparam logic [2:0] C_IORD = 3'b001;
  localparam logic [2:0] C_IOWR = 3'b010;
  localparam logic [2:0] C_HALT = 3'b011;
  localparam logic [2:0] C_FTCH = 3'b100;
  localparam logic [2:0] C_MRD  = 3'b101;
  localparam logic [2:0] C_MWR  = 3'b110;
  localparam logic [2:0] C_IDLE = 3'b111;

  typedef enum logic [2:0] {P_IDLE, P_T1, P_T2, P_T3, P_TW, P_T4} phase_t;

  phase_t     phase, phase_nx;
  logic [2:0] code, prev_stat;
  logic       start;

  assign start = (phase == P_IDLE || phase == P_T4) &&
                 stat != C_IDLE && prev_stat == C_IDLE;

  always_comb begin
    phase_nx = phase;
    case (phase)
      P_IDLE:  if (start) phase_nx = P_T1;
      P_T1:    phase_nx = P_T2;
      P_T2:    phase_nx = P_T3;
      P_T3:    phase_nx = rdy ? P_T4 : P_TW;
      P_TW:    phase_nx = rdy ? P_T4 : P_TW;
      P_T4:    phase_nx = start ? P_T1 : P_IDLE;
      default: phase_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      code      <= C_IDLE;
      prev_stat <= C_IDLE;
    end else begin
      phase     <= phase_nx;
      prev_stat <= stat;
      if (start) code <= stat;
    end
  end

  logic in_cyc, data_ph, late_ph;
  logic is_ack, is_iord, is_iowr, is_halt, is_mrd, is_mwr;

  assign in_cyc  = phase != P_IDLE;
  assign data_ph = phase == P_T2 || phase == P_T3 || phase == P_TW || phase == P_T4;
  assign late_ph = phase == P_T3 || phase == P_TW || phase == P_T4;

  assign is_ack  = code == C_ACK;
  assign is_iord = code == C_IORD;
  assign is_iowr = code == C_IOWR;
  assign is_halt = code == C_HALT;
  assign is_mrd  = code == C_FTCH || code == C_MRD;
  assign is_mwr  = code == C_MWR;

  assign ale       = phase == P_T1;
  assign dir_tx    = in_cyc && (is_iowr || is_mwr);
  assign den       = data_ph && !is_halt;
  assign mem_rd_n  = !(data_ph && is_mrd);
  assign io_rd_n   = !(data_ph && is_iord);
  assign ack_n     = !(data_ph && is_ack);
  assign mem_awr_n = !(data_ph && is_mwr);
  assign io_awr_n  = !(data_ph && is_iowr);
  assign mem_wr_n  = !(late_ph && is_mwr);
  assign io_wr_n   = !(late_ph && is_iowr);

endmodule

// File: rtl/bus_cmd_decoder_chk.sv
module bus_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] stat,
  input logic       rdy,
  input logic       ale,
  input logic       dir_tx,
  input logic       den,
  input logic       mem_rd_n,
  input logic       mem_wr_n,
  input logic       mem_awr_n,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic       io_awr_n,
  input logic       ack_n
);

  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mem_rd_n, !io_rd_n, !ack_n, !mem_awr_n, !io_awr_n}));

  assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_dir_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    den |-> $stable(dir_tx));

  assert_den_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !io_rd_n || !ack_n || !mem_awr_n || !io_awr_n) |-> den);

  assert_mem_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !mem_awr_n);

  assert_io_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr_n |-> !io_awr_n);

  assert_mem_wr_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> $past(!mem_awr_n));

  assert_io_wr_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_wr_n) |-> $past(!io_awr_n));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |=> !mem_wr_n);

endmodule

bind bus_cmd_decoder bus_cmd_decoder_chk u_chk (.*);

// File: tb/sim_bus_cmd_decoder.sv
module sim_bus_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, rdy = 1;
  logic [2:0] stat = 3'b111;
  logic ale, dir_tx, den, mem_rd_n, mem_wr_n, mem_awr_n, io_rd_n, io_wr_n, io_awr_n, ack_n;

  int compared = 0, mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_decoder u0 (.clk, .rst_n, .stat, .rdy, .ale, .dir_tx, .den,
    .mem_rd_n, .mem_wr_n, .mem_awr_n, .io_rd_n, .io_wr_n, .io_awr_n, .ack_n);

  // model phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
  int ph = 0, cd = 7, pv = 7;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cd = 7; pv = 7;
    end else begin
      bit go;
      go = (ph == 0 || ph == 5) && stat != 3'b111 && pv == 7;
      if (go) begin ph = 1; cd = stat; end
      else if (ph == 5) ph = 0;
      else if (ph == 3 || ph == 4) ph = rdy ? 5 : 4;
      else if (ph != 0) ph = ph + 1;
      pv = stat;
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit data, late, wrc;
    data = ph >= 2;
    late = ph >= 3;
    wrc  = (cd == 2 || cd == 6);
    chk("R3", "ale", ale, ph == 1);
    chk("R4", "dir_tx", dir_tx, ph != 0 && wrc);
    chk(cd == 3 ? "R10" : "R5", "den", den, data && cd != 3);
    chk("R6", "mem_rd_n", mem_rd_n, !(data && (cd == 4 || cd == 5)));
    chk("R6", "io_rd_n", io_rd_n, !(data && cd == 1));
    chk("R7", "ack_n", ack_n, !(data && cd == 0));
    chk("R8", "mem_awr_n", mem_awr_n, !(data && cd == 6));
    chk("R8", "io_awr_n", io_awr_n, !(data && cd == 2));
    chk("R9", "mem_wr_n", mem_wr_n, !(late && cd == 6));
    chk("R9", "io_wr_n", io_wr_n, !(late && cd == 2));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  // one cycle: code held for two clocks, passive afterwards; rdy low for w clocks from T3
  task automatic bus_cycle(input logic [2:0] c, input int w);
    stat = c; rdy = 1;
    step(2);
    stat = 3'b111;
    step(1);
    rdy = (w == 0);
    for (int i = 0; i < w; i++) begin
      step(1);
      if (i == w - 1) rdy = 1;
    end
    step(1);
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    step(3);
    @(negedge clk) rst_n = 1;
    step(2);
    // R2 R6 R7 R8 R9 R10 every code, no wait states
    for (int c = 0; c < 7; c++) begin
      bus_cycle(3'(c), 0);
      step(2); // R13 release after T4
    end
    // R11 wait states
    bus_cycle(3'b110, 1); step(1);
    bus_cycle(3'b010, 3); step(1);
    bus_cycle(3'b101, 5); step(1);
    bus_cycle(3'b000, 2); step(1);
    bus_cycle(3'b011, 2); step(1);
    // R1 back-to-back: new code appears during T4
    stat = 3'b110; step(2); stat = 3'b111; step(2);
    stat = 3'b001; step(2); stat = 3'b111; step(2);
    stat = 3'b100; step(2); stat = 3'b111; step(4);
    // R1 status changes mid-cycle are ignored
    stat = 3'b101; step(1);
    stat = 3'b111; step(1);
    stat = 3'b010; step(1);
    stat = 3'b111; step(5);
    // R1 status that stays non-passive starts only one cycle
    stat = 3'b001; step(10);
    stat = 3'b111; step(3);
    // R12 reset in the middle of a write cycle
    stat = 3'b110; step(3);
    @(negedge clk) rst_n = 0;
    stat = 3'b111;
    step(2);
    @(negedge clk) rst_n = 1;
    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule